// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block keeps time in a slow, always-on clock domain. A 47-bit counter steps once per reference clock, normally 32.768 kHz. Its upper 32 bits count whole seconds and its lower 15 bits hold the fraction of a second. A 47-bit alarm value is compared with the counter on every cycle. When the two are equal, a sticky alarm flag is raised, and that flag can drive an interrupt output.

Software reaches the block through a register write port that has already been synchronized into the slow domain, and through a combinational read port. After power-on the counter stays frozen until its seconds word has been written once, even if the value written is zero. After that, it counts only while the enable bit in the control register is set. Power-on also sets a non-valid flag and a violation flag. Alarm matching stays suppressed until software clears both flags in a single status write. No periodic interrupt is generated.

Top module: `lp_sec_timer`

## Requirements
- R1: After reset, all of the following hold:
  - The counter reads 0 (seconds and fraction).
  - The control word reads 0.
  - The status word reads 0x3: violation flag at bit 0, non-valid flag at bit 1, alarm flag at bit 4 clear.
  - The alarm reads seconds 0xFFFFFFFF with fraction 0.
  - The interrupt enable reads 0 and irq_o is low.
- R2: Until the seconds word (index 0) has been written once, the counter does not advance, whatever the value of the enable bit.
- R3: Once the seconds word has been written, the 47-bit counter advances by one on each clock while control bit 3 (index 4) is set, and holds while that bit is clear.
- R4: The 15-bit fraction (index 1, bits 14:0) wraps from 32767 to 0 and carries one into the seconds word. The full counter wraps from all ones to zero.
- R5: Writes load the selected fields:
  - Index 0 loads the seconds and index 1 loads the fraction.
  - Index 2 loads the alarm seconds and index 3 loads the alarm fraction.
  - A counter write takes precedence over that cycle's increment.
- R6: The alarm flag (status bit 4) is set on the clock after the counter equals the alarm value on all 47 bits. It is set only while the non-valid flag is clear, so it is raised once per match.
- R7: The alarm flag stays set until a status write (index 5) with bit 4 at 1. If a new match occurs in the same cycle, the set wins over the clear.
- R8: The non-valid and violation flags clear only on a status write that has bits 1 and 0 both at 1. A write with only one of these bits at 1 changes neither flag.
- R9: irq_o is high exactly while both the alarm flag and bit 4 of the interrupt-enable register (index 6) are set.
- R10: Read indices match the write indices (0 to 6). Unused bits and unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-power reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Synchronized register write strobe |
| wr_sel_i | input | 3 | Register index for the write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register index for the read |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that writes reach the port already synchronized to clk_i, as single-cycle strobes with stable index and data. They also assume that a register write is the only way software touches the state. The stimulus drives every write for exactly one clock, between falling edges, and changes the read index only when no result depends on it. The counter is stopped, through the enable bit, whenever an exact fraction value must be checked. Alarm timing is measured from the control write that starts counting.

// File: rtl/lp_sec_pkg.sv
package lp_sec_pkg;
  typedef enum logic [2:0] {
    IDX_SEC     = 3'd0,
    IDX_FRAC    = 3'd1,
    IDX_ALM_SEC = 3'd2,
    IDX_ALM_FRC = 3'd3,
    IDX_CTRL    = 3'd4,
    IDX_STAT    = 3'd5,
    IDX_IEN     = 3'd6
  } reg_idx_e;

  localparam int unsigned CTRL_RUN_BIT = 3;
  localparam int unsigned STAT_ALM_BIT = 4;
  localparam int unsigned STAT_NV_BIT  = 1;
  localparam int unsigned STAT_SV_BIT  = 0;
  localparam int unsigned IEN_ALM_BIT  = 4;
endpackage

// File: rtl/lp_sec_counter.sv
module lp_sec_counter #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = SEC_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              sec_we_i,
  input  logic              frac_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             step;

  assign step  = run_i && armed_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sec_we_i || frac_we_i) begin
        if (sec_we_i)  cnt_q[CNT_W-1:FRAC_W] <= wdata_i[SEC_W-1:0];
        if (frac_we_i) cnt_q[FRAC_W-1:0]     <= wdata_i[FRAC_W-1:0];
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;  // fraction carry and full wrap fall out of the sum
      end
      if (sec_we_i) armed_q <= 1'b1;
    end
  end

  a_r2_frozen_until_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !sec_we_i && !frac_we_i) |=> (cnt_q == $past(cnt_q)));
  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && armed_q && !sec_we_i && !frac_we_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r3_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sec_we_i && !frac_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lp_sec_alarm.sv
module lp_sec_alarm #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = SEC_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_we_i,
  input  logic              frac_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cmp_en_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  alm_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] alm_q;
  logic             flag_q;
  logic             hit;

  assign hit    = cmp_en_i && (cnt_i == alm_q);
  assign alm_o  = alm_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};
      flag_q <= 1'b0;
    end else begin
      if (sec_we_i)  alm_q[CNT_W-1:FRAC_W] <= wdata_i[SEC_W-1:0];
      if (frac_we_i) alm_q[FRAC_W-1:0]     <= wdata_i[FRAC_W-1:0];
      if (hit)        flag_q <= 1'b1;   // new match beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r6_suppressed_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !cmp_en_i) |=> !flag_q);
endmodule

// File: rtl/lp_sec_timer.sv
module lp_sec_timer
  import lp_sec_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt, alm;
  logic             run_q, ien_q, nv_q, sv_q, alm_flag;
  logic             we_sec, we_frac, we_asec, we_afrac, we_ctrl, we_stat, we_ien;
  logic             valid_clr, alm_clr;

  assign we_sec   = wr_en_i && (wr_sel_i == IDX_SEC);
  assign we_frac  = wr_en_i && (wr_sel_i == IDX_FRAC);
  assign we_asec  = wr_en_i && (wr_sel_i == IDX_ALM_SEC);
  assign we_afrac = wr_en_i && (wr_sel_i == IDX_ALM_FRC);
  assign we_ctrl  = wr_en_i && (wr_sel_i == IDX_CTRL);
  assign we_stat  = wr_en_i && (wr_sel_i == IDX_STAT);
  assign we_ien   = wr_en_i && (wr_sel_i == IDX_IEN);

  assign valid_clr = we_stat && wr_data_i[STAT_NV_BIT] && wr_data_i[STAT_SV_BIT];
  assign alm_clr   = we_stat && wr_data_i[STAT_ALM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      nv_q  <= 1'b1;
      sv_q  <= 1'b1;
    end else begin
      if (we_ctrl)   run_q <= wr_data_i[CTRL_RUN_BIT];
      if (we_ien)    ien_q <= wr_data_i[IEN_ALM_BIT];
      if (valid_clr) begin
        nv_q <= 1'b0;
        sv_q <= 1'b0;
      end
    end
  end

  lp_sec_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .sec_we_i  (we_sec),
    .frac_we_i (we_frac),
    .wdata_i   (wr_data_i),
    .cnt_o     (cnt)
  );

  lp_sec_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_we_i  (we_asec),
    .frac_we_i (we_afrac),
    .wdata_i   (wr_data_i),
    .cnt_i     (cnt),
    .cmp_en_i  (!nv_q),
    .clr_i     (alm_clr),
    .alm_o     (alm),
    .flag_o    (alm_flag)
  );

  assign irq_o = alm_flag && ien_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      IDX_SEC:     rd_data_o[SEC_W-1:0]  = cnt[CNT_W-1:FRAC_W];
      IDX_FRAC:    rd_data_o[FRAC_W-1:0] = cnt[FRAC_W-1:0];
      IDX_ALM_SEC: rd_data_o[SEC_W-1:0]  = alm[CNT_W-1:FRAC_W];
      IDX_ALM_FRC: rd_data_o[FRAC_W-1:0] = alm[FRAC_W-1:0];
      IDX_CTRL:    rd_data_o[CTRL_RUN_BIT] = run_q;
      IDX_STAT: begin
        rd_data_o[STAT_ALM_BIT] = alm_flag;
        rd_data_o[STAT_NV_BIT]  = nv_q;
        rd_data_o[STAT_SV_BIT]  = sv_q;
      end
      IDX_IEN:     rd_data_o[IEN_ALM_BIT] = ien_q;
      default:     rd_data_o = '0;
    endcase
  end

  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_q && !valid_clr) |=> (nv_q && sv_q));
  a_r8_never_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nv_q |=> !nv_q);
endmodule

// File: tb/tb_lp_sec_timer.sv
module tb_lp_sec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lp_sec_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  ws;
    logic [31:0] wd;
    logic [7:0]  idle;
    logic [2:0]  rs;
    logic [31:0] exp;
  } vec_t;

  // Starts from the reset state: stopped, never armed.
  localparam vec_t VECS [18] = '{
    '{1'b1, 3'd4, 32'h8,        8'd4,  3'd1, 32'd0},         // R2 enabled but unarmed
    '{1'b1, 3'd1, 32'd100,      8'd2,  3'd1, 32'd100},       // R2/R5 frac load, still frozen
    '{1'b1, 3'd4, 32'h0,        8'd0,  3'd4, 32'h0},         // R10 ctrl readback
    '{1'b1, 3'd0, 32'd7,        8'd3,  3'd0, 32'd7},         // R5 arm with sec write
    '{1'b0, 3'd0, 32'd0,        8'd0,  3'd1, 32'd100},       // R3 stopped holds
    '{1'b1, 3'd4, 32'h8,        8'd10, 3'd1, 32'd110},       // R3 counts ten
    '{1'b0, 3'd0, 32'd0,        8'd0,  3'd4, 32'h8},         // R10 ctrl run bit
    '{1'b1, 3'd4, 32'h0,        8'd0,  3'd1, 32'd111},       // R3 stop edge still counts
    '{1'b0, 3'd0, 32'd0,        8'd0,  3'd0, 32'd7},         // R3 sec unchanged
    '{1'b1, 3'd1, 32'h7FFE,     8'd0,  3'd1, 32'h7FFE},      // R5
    '{1'b1, 3'd4, 32'h8,        8'd2,  3'd1, 32'd0},         // R4 fraction wrap
    '{1'b0, 3'd0, 32'd0,        8'd0,  3'd0, 32'd8},         // R4 carry
    '{1'b1, 3'd4, 32'h0,        8'd0,  3'd1, 32'd1},         // R3
    '{1'b1, 3'd0, 32'hFFFFFFFF, 8'd0,  3'd0, 32'hFFFFFFFF},  // R5
    '{1'b1, 3'd1, 32'hFFFF7FFF, 8'd0,  3'd1, 32'h7FFF},      // R10 upper bits dropped
    '{1'b1, 3'd4, 32'h8,        8'd1,  3'd0, 32'd0},         // R4 full wrap sec
    '{1'b0, 3'd0, 32'd0,        8'd0,  3'd1, 32'd0},         // R4 full wrap frac
    '{1'b1, 3'd4, 32'h0,        8'd0,  3'd1, 32'd1}          // R3
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [2:0] s, logic [31:0] exp);
    rd_sel = s;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 sec", 3'd0, 32'd0);
    rd_chk("R1 frac", 3'd1, 32'd0);
    rd_chk("R1 alm sec", 3'd2, 32'hFFFFFFFF);
    rd_chk("R1 alm frac", 3'd3, 32'd0);
    rd_chk("R1 ctrl", 3'd4, 32'd0);
    rd_chk("R1 status", 3'd5, 32'h3);
    rd_chk("R1 ien", 3'd6, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd_chk("R10 unused idx", 3'd7, 32'd0);

    foreach (VECS[i]) begin
      if (VECS[i].we) wr(VECS[i].ws, VECS[i].wd);
      repeat (int'(VECS[i].idle)) @(negedge clk);
      rd_chk($sformatf("table R2-vec%0d", i), VECS[i].rs, VECS[i].exp);
    end
    // counter now stopped at sec 0 frac 1

    // R6: match suppressed while non-valid
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd3);
    wr(3'd6, 32'h10);
    rd_chk("R10 ien", 3'd6, 32'h10);
    wr(3'd4, 32'h8);
    repeat (10) @(negedge clk);
    wr(3'd4, 32'h0);
    rd_chk("R6 suppressed", 3'd5, 32'h3);
    check("R6 no irq", {31'd0, irq}, 32'd0);

    // R8: partial clears ignored
    wr(3'd5, 32'h2);
    rd_chk("R8 nv only", 3'd5, 32'h3);
    wr(3'd5, 32'h1);
    rd_chk("R8 sv only", 3'd5, 32'h3);
    wr(3'd5, 32'h3);
    rd_chk("R8 both clear", 3'd5, 32'h0);

    // R6: exact timing of the match
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd4, 32'h8);
    repeat (2) @(negedge clk);
    rd_chk("R6 before match", 3'd5, 32'h0);
    @(negedge clk);
    rd_chk("R6 match cycle frac", 3'd1, 32'd3);
    rd_chk("R6 flag not yet", 3'd5, 32'h0);
    @(negedge clk);
    rd_chk("R6 flag set", 3'd5, 32'h10);
    check("R9 irq high", {31'd0, irq}, 32'd1);

    // R7: sticky while counter moves past
    repeat (20) @(negedge clk);
    rd_chk("R7 sticky", 3'd5, 32'h10);
    wr(3'd5, 32'h0);
    rd_chk("R7 zero write no clear", 3'd5, 32'h10);

    // R9 gating
    wr(3'd6, 32'h0);
    check("R9 masked", {31'd0, irq}, 32'd0);
    rd_chk("R9 flag kept", 3'd5, 32'h10);
    wr(3'd6, 32'h10);
    check("R9 unmasked", {31'd0, irq}, 32'd1);

    // R7 clear, R6 no refire past match
    wr(3'd5, 32'h10);
    rd_chk("R7 cleared", 3'd5, 32'h0);
    check("R9 irq low", {31'd0, irq}, 32'd0);
    repeat (20) @(negedge clk);
    rd_chk("R6 once per match", 3'd5, 32'h0);

    // R7: set wins over clear in same cycle
    wr(3'd4, 32'h0);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd2);       // next cycle counter holds 2 while stopped
    wr(3'd3, 32'd2);       // alarm now equals counter
    wr(3'd5, 32'h10);      // clear while match still holds
    rd_chk("R7 set beats clear", 3'd5, 32'h10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule